// File: doc/BRIEF.md
# Multicore Cluster Control Register Block

This block is the memory-mapped control point for a processor cluster of up to eight cores, four by default. A 32-bit register bus that moves only whole, aligned words reaches it. Each core has a 64-bit boot address, held in two words and driven out as its own port. Software raises interrupt sources through a write-one-to-clear status word. A mask is changed only through a pair of enable and disable ports, and the unmasked pending sources drive a single interrupt line.

A per-core power-down request word feeds the power manager in two ways. Each core's power-status output follows its request bit. Each core's wait-for-interrupt output is raised only while that core has asked to power down and also reports that it is idle. Three further words are plain storage for cluster control, coherency control and snoop control. They have no side effects.

Read data is combinational from the address presented. A write takes effect on the clock edge where it is presented. Any access that is not word-aligned, or that hits an offset with no register, reads zero and changes nothing.

Top module: `cluster_ctrl`

## Requirements
- R1: Reset values are as follows. Each boot address low word is 0xFFFF0000, and each high word is 0. The mask reads all ones in its IRQ_W bits. The status word, the power-down request word and the three storage words are 0. After reset no power-status or wait-for-interrupt output is high, whatever the idle inputs are.
- R2: Core c has its boot address low word at offset 0x40+8c and its high word at 0x44+8c. Both are fully writable and readable. boot_addr_o[c] equals {high, low}, with the high word in bits 63:32.
- R3: The status word at 0x10 holds IRQ_W bits, read in bits IRQ_W-1:0. Writing a 1 to a bit clears that bit. A high irq_set_i bit sets its status bit on the next edge. When a set and a clear of the same bit fall on one edge, the set wins.
- R4: The mask at 0x14 is read-only. A write to 0x14 leaves it unchanged. The mask changes on no edge without an enable or disable write.
- R5: A write to 0x18 clears the mask bits given as 1. A write to 0x1C sets the mask bits given as 1. Bits given as 0 are unchanged. Both offsets read as 0.
- R6: irq_o is high exactly when some status bit is 1 and its mask bit is 0. It follows the register state with no added delay.
- R7: The power-down request word at 0x90 is readable and writable in bits NCORE-1:0, and its upper bits read 0. When a write changes a core's request bit, that core's pwr_stat_o takes the new value from the next edge. pwr_stat_o changes on no edge without a write to 0x90.
- R8: wfi_o[c] is the AND of request bit c and wfi_i[c]. It follows either one combinationally.
- R9: Offset 0x94 is read-only. It returns wfi_i in bits NCORE-1:0 and 0 above.
- R10: Offsets 0x00, 0x80 and 0x84 are independent 32-bit read/write storage words.
- R11: An access whose address has bits 1:0 not zero, or whose offset holds no register, reads 0 and changes no state.
- R12: bus_rdata carries the addressed value while bus_sel is high and bus_wr is low, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_set_i | input | IRQ_W | Per-source status set events |
| wfi_i | input | NCORE | Per-core idle (wait-for-interrupt) indication |
| irq_o | output | 1 | Unmasked pending interrupt |
| wfi_o | output | NCORE | Per-core idle-and-power-down-requested |
| pwr_stat_o | output | NCORE | Per-core power-status, follows request bits |
| boot_addr_o | output | NCORE x 64 | Per-core 64-bit boot address |

## Verification
Directed steps come first. They set and clear status bits on the same edge, which separates set priority from clear priority. They write the mask at its read-only offset and at unaligned addresses, which separates decoded writes from ignored ones. Driving power-down writes while wfi_i is held at a different pattern shows whether wfi_o follows the AND of the two rather than either input alone. A long run of random accesses follows. It uses random offsets, including misaligned and empty ones, random data, sparse set events and changing idle inputs. A reference model in the bench predicts every read and every output, which catches wrong decodes, aliasing between boot address words, and mask ports that touch bits they were not given.

// File: rtl/cc_pkg.sv
package cc_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned OFF_CTRL   = 'h00;
   localparam int unsigned OFF_STAT   = 'h10;
   localparam int unsigned OFF_MASK   = 'h14;
   localparam int unsigned OFF_UNMASK = 'h18;
   localparam int unsigned OFF_DOMASK = 'h1C;
   localparam int unsigned OFF_BOOT   = 'h40;
   localparam int unsigned OFF_COH    = 'h80;
   localparam int unsigned OFF_SNOOP  = 'h84;
   localparam int unsigned OFF_PDREQ  = 'h90;
   localparam int unsigned OFF_IDLE   = 'h94;
   localparam logic [31:0] BOOT_LO_RST = 32'hFFFF_0000;
   localparam logic [31:0] BOOT_HI_RST = 32'h0000_0000;

   typedef enum logic [3:0] {
      SRC_NONE, SRC_CTRL, SRC_STAT, SRC_MASK, SRC_UNMASK, SRC_DOMASK,
      SRC_BOOT, SRC_COH, SRC_SNOOP, SRC_PDREQ, SRC_IDLE
   } rd_src_e;

   typedef struct packed {
      logic ctrl;
      logic stat;
      logic unmask;
      logic domask;
      logic coh;
      logic snoop;
      logic pdreq;
   } wr_stb_t;
endpackage

// File: rtl/cc_bus_decode.sv
module cc_bus_decode
   import cc_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NCORE  = 4
) (
   input  logic                       bus_sel,
   input  logic                       bus_wr,
   input  logic [ADDR_W-1:0]          bus_addr,
   output wr_stb_t                    wstb,
   output logic [2*NCORE-1:0]         boot_we,
   output rd_src_e                    rsrc,
   output logic [$clog2(2*NCORE)-1:0] boot_idx
);
   localparam int unsigned BOOT_WORDS = 2 * NCORE;
   localparam int unsigned IDX_W      = $clog2(BOOT_WORDS);
   localparam logic [ADDR_W-1:0] BOOT_LO_A = ADDR_W'(OFF_BOOT);
   localparam logic [ADDR_W-1:0] BOOT_HI_A = ADDR_W'(OFF_BOOT + 4 * BOOT_WORDS);

   logic              aligned;
   logic              wr_act;
   logic [ADDR_W-1:0] boot_off;

   assign aligned  = (bus_addr[1:0] == 2'b00);
   assign wr_act   = bus_sel && bus_wr && aligned;
   assign boot_off = bus_addr - BOOT_LO_A;

   always_comb begin
      rsrc     = SRC_NONE;
      boot_idx = '0;
      if (aligned) begin
         if (bus_addr >= BOOT_LO_A && bus_addr < BOOT_HI_A) begin
            rsrc     = SRC_BOOT;
            boot_idx = boot_off[IDX_W+1:2];
         end else begin
            case (bus_addr)
               ADDR_W'(OFF_CTRL):   rsrc = SRC_CTRL;
               ADDR_W'(OFF_STAT):   rsrc = SRC_STAT;
               ADDR_W'(OFF_MASK):   rsrc = SRC_MASK;
               ADDR_W'(OFF_UNMASK): rsrc = SRC_UNMASK;
               ADDR_W'(OFF_DOMASK): rsrc = SRC_DOMASK;
               ADDR_W'(OFF_COH):    rsrc = SRC_COH;
               ADDR_W'(OFF_SNOOP):  rsrc = SRC_SNOOP;
               ADDR_W'(OFF_PDREQ):  rsrc = SRC_PDREQ;
               ADDR_W'(OFF_IDLE):   rsrc = SRC_IDLE;
               default:             rsrc = SRC_NONE;
            endcase
         end
      end
   end

   always_comb begin
      wstb.ctrl   = wr_act && (rsrc == SRC_CTRL);
      wstb.stat   = wr_act && (rsrc == SRC_STAT);
      wstb.unmask = wr_act && (rsrc == SRC_UNMASK);
      wstb.domask = wr_act && (rsrc == SRC_DOMASK);
      wstb.coh    = wr_act && (rsrc == SRC_COH);
      wstb.snoop  = wr_act && (rsrc == SRC_SNOOP);
      wstb.pdreq  = wr_act && (rsrc == SRC_PDREQ);
   end

   generate
      for (genvar w = 0; w < BOOT_WORDS; w++) begin : g_we
         assign boot_we[w] = wr_act && (rsrc == SRC_BOOT) && (boot_idx == IDX_W'(w));
      end
   endgenerate
endmodule

// File: rtl/cc_boot_bank.sv
module cc_boot_bank
   import cc_pkg::*;
#(
   parameter int unsigned NCORE = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [2*NCORE-1:0]             we,
   input  logic [WORD_W-1:0]              wdata,
   input  logic [$clog2(2*NCORE)-1:0]     rd_idx,
   output logic [WORD_W-1:0]              rdata,
   output logic [NCORE-1:0][63:0]         boot_addr
);
   localparam int unsigned BOOT_WORDS = 2 * NCORE;

   logic [BOOT_WORDS-1:0][WORD_W-1:0] words;

   generate
      for (genvar w = 0; w < BOOT_WORDS; w++) begin : g_word
         localparam logic [WORD_W-1:0] RST_V = ((w % 2) == 0) ? BOOT_LO_RST : BOOT_HI_RST;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     words[w] <= RST_V;
            else if (we[w]) words[w] <= wdata;
         end
      end
      for (genvar c = 0; c < NCORE; c++) begin : g_core
         assign boot_addr[c] = {words[2*c+1], words[2*c]};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int w = 0; w < BOOT_WORDS; w++) begin
         if (int'(rd_idx) == w) rdata = words[w];
      end
   end
endmodule

// File: rtl/cc_irq_unit.sv
module cc_irq_unit #(
   parameter int unsigned IRQ_W       = 8,
   parameter bit          IRQ_OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stat_we,
   input  logic             unmask_we,
   input  logic             domask_we,
   input  logic [IRQ_W-1:0] wdata,
   input  logic [IRQ_W-1:0] set_i,
   output logic [IRQ_W-1:0] stat_q,
   output logic [IRQ_W-1:0] mask_q,
   output logic             irq_o
);
   logic [IRQ_W-1:0] clr_bits;
   logic             pend;

   assign clr_bits = stat_we ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_q & ~clr_bits) | set_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '1;
      else if (unmask_we) mask_q <= mask_q & ~wdata;
      else if (domask_we) mask_q <= mask_q | wdata;
   end

   assign pend = |(stat_q & ~mask_q);

   generate
      if (IRQ_OUT_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= pend;
         end
      end else begin : g_irq_comb
         assign irq_o = pend;
      end
   endgenerate
endmodule

// File: rtl/cc_pwr_unit.sv
module cc_pwr_unit #(
   parameter int unsigned NCORE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [NCORE-1:0] wdata,
   input  logic [NCORE-1:0] wfi_i,
   output logic [NCORE-1:0] pdreq_q,
   output logic [NCORE-1:0] wfi_o,
   output logic [NCORE-1:0] stat_o
);
   generate
      for (genvar c = 0; c < NCORE; c++) begin : g_core
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  pdreq_q[c] <= 1'b0;
            else if (we) pdreq_q[c] <= wdata[c];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           stat_o[c] <= 1'b0;
            else if (we && wdata[c] != pdreq_q[c]) stat_o[c] <= wdata[c];
         end
         assign wfi_o[c] = pdreq_q[c] & wfi_i[c];
      end
   endgenerate
endmodule

// File: rtl/cluster_ctrl.sv
module cluster_ctrl
   import cc_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned NCORE       = 4,
   parameter int unsigned IRQ_W       = 8,
   parameter bit          IRQ_OUT_REG = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [IRQ_W-1:0]       irq_set_i,
   input  logic [NCORE-1:0]       wfi_i,
   output logic                   irq_o,
   output logic [NCORE-1:0]       wfi_o,
   output logic [NCORE-1:0]       pwr_stat_o,
   output logic [NCORE-1:0][63:0] boot_addr_o
);
   localparam int unsigned IDX_W = $clog2(2 * NCORE);

   generate
      if (NCORE < 1 || NCORE > 8) begin : g_bad_ncore
         $error("cluster_ctrl: NCORE must be 1..8");
      end
      if (IRQ_W < 1 || IRQ_W > 32) begin : g_bad_irqw
         $error("cluster_ctrl: IRQ_W must be 1..32");
      end
      if (ADDR_W < 8) begin : g_bad_addrw
         $error("cluster_ctrl: ADDR_W must be at least 8");
      end
   endgenerate

   wr_stb_t                 wstb;
   logic [2*NCORE-1:0]      boot_we;
   rd_src_e                 rsrc;
   logic [IDX_W-1:0]        boot_idx;
   logic [WORD_W-1:0]       boot_rdata;
   logic [IRQ_W-1:0]        stat_q;
   logic [IRQ_W-1:0]        mask_q;
   logic [NCORE-1:0]        pdreq_q;
   logic [WORD_W-1:0]       ctrl_q, coh_q, snoop_q;
   logic [WORD_W-1:0]       rd_mux;

   cc_bus_decode #(.ADDR_W(ADDR_W), .NCORE(NCORE)) u_dec (
      .bus_sel  (bus_sel),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .wstb     (wstb),
      .boot_we  (boot_we),
      .rsrc     (rsrc),
      .boot_idx (boot_idx)
   );

   cc_boot_bank #(.NCORE(NCORE)) u_boot (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (boot_we),
      .wdata     (bus_wdata),
      .rd_idx    (boot_idx),
      .rdata     (boot_rdata),
      .boot_addr (boot_addr_o)
   );

   cc_irq_unit #(.IRQ_W(IRQ_W), .IRQ_OUT_REG(IRQ_OUT_REG)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .stat_we   (wstb.stat),
      .unmask_we (wstb.unmask),
      .domask_we (wstb.domask),
      .wdata     (bus_wdata[IRQ_W-1:0]),
      .set_i     (irq_set_i),
      .stat_q    (stat_q),
      .mask_q    (mask_q),
      .irq_o     (irq_o)
   );

   cc_pwr_unit #(.NCORE(NCORE)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (wstb.pdreq),
      .wdata   (bus_wdata[NCORE-1:0]),
      .wfi_i   (wfi_i),
      .pdreq_q (pdreq_q),
      .wfi_o   (wfi_o),
      .stat_o  (pwr_stat_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         coh_q   <= '0;
         snoop_q <= '0;
      end else begin
         if (wstb.ctrl)  ctrl_q  <= bus_wdata;
         if (wstb.coh)   coh_q   <= bus_wdata;
         if (wstb.snoop) snoop_q <= bus_wdata;
      end
   end

   always_comb begin
      case (rsrc)
         SRC_CTRL:  rd_mux = ctrl_q;
         SRC_STAT:  rd_mux = WORD_W'(stat_q);
         SRC_MASK:  rd_mux = WORD_W'(mask_q);
         SRC_BOOT:  rd_mux = boot_rdata;
         SRC_COH:   rd_mux = coh_q;
         SRC_SNOOP: rd_mux = snoop_q;
         SRC_PDREQ: rd_mux = WORD_W'(pdreq_q);
         SRC_IDLE:  rd_mux = WORD_W'(wfi_i);
         default:   rd_mux = '0;
      endcase
   end

   assign bus_rdata = (bus_sel && !bus_wr) ? rd_mux : '0;
endmodule

// File: rtl/cluster_ctrl_chk.sv
module cluster_ctrl_chk #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned NCORE  = 4,
   parameter int unsigned IRQ_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [IRQ_W-1:0]  irq_set_i,
   input logic [NCORE-1:0]  wfi_i,
   input logic [NCORE-1:0]  wfi_o,
   input logic [NCORE-1:0]  pwr_stat_o,
   input logic [IRQ_W-1:0]  stat_q,
   input logic [IRQ_W-1:0]  mask_q
);
   logic wr_any, unmask_wr, domask_wr, pdreq_wr;
   assign wr_any    = bus_sel && bus_wr;
   assign unmask_wr = wr_any && bus_addr == ADDR_W'(cc_pkg::OFF_UNMASK);
   assign domask_wr = wr_any && bus_addr == ADDR_W'(cc_pkg::OFF_DOMASK);
   assign pdreq_wr  = wr_any && bus_addr == ADDR_W'(cc_pkg::OFF_PDREQ);

   assert_unmask_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      unmask_wr |=> ((mask_q & $past(bus_wdata[IRQ_W-1:0])) == '0));

   assert_domask_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      domask_wr |=> ((mask_q & $past(bus_wdata[IRQ_W-1:0])) == $past(bus_wdata[IRQ_W-1:0])));

   assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(unmask_wr || domask_wr) |=> $stable(mask_q));

   assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_set_i) |=> ((stat_q & $past(irq_set_i)) == $past(irq_set_i)));

   assert_wfi_needs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wfi_o & ~wfi_i) == '0);

   assert_wfi_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wfi_o & ~pwr_stat_o) == '0);

   assert_stat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pdreq_wr |=> $stable(pwr_stat_o));
endmodule

bind cluster_ctrl cluster_ctrl_chk #(.ADDR_W(ADDR_W), .NCORE(NCORE), .IRQ_W(IRQ_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .irq_set_i  (irq_set_i),
   .wfi_i      (wfi_i),
   .wfi_o      (wfi_o),
   .pwr_stat_o (pwr_stat_o),
   .stat_q     (stat_q),
   .mask_q     (mask_q)
);

// File: tb/test_cluster_ctrl.sv
module test_cluster_ctrl;
   localparam int ADDR_W = 8;
   localparam int NCORE  = 4;
   localparam int IRQ_W  = 8;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   bus_sel = 1'b0;
   logic                   bus_wr = 1'b0;
   logic [ADDR_W-1:0]      bus_addr = '0;
   logic [31:0]            bus_wdata = '0;
   logic [31:0]            bus_rdata;
   logic [IRQ_W-1:0]       irq_set_i = '0;
   logic [NCORE-1:0]       wfi_i = '1;
   logic                   irq_o;
   logic [NCORE-1:0]       wfi_o;
   logic [NCORE-1:0]       pwr_stat_o;
   logic [NCORE-1:0][63:0] boot_addr_o;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0]      m_ctrl, m_coh, m_snoop;
   logic [IRQ_W-1:0] m_stat, m_mask;
   logic [NCORE-1:0] m_pd, m_pstat;
   logic [31:0]      m_boot [2*NCORE];

   always #5 clk = ~clk;

   cluster_ctrl #(.ADDR_W(ADDR_W), .NCORE(NCORE), .IRQ_W(IRQ_W)) i_cluster_ctrl (
      .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .irq_set_i (irq_set_i), .wfi_i (wfi_i), .irq_o (irq_o), .wfi_o (wfi_o),
      .pwr_stat_o (pwr_stat_o), .boot_addr_o (boot_addr_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic bit is_boot(input logic [7:0] a);
      return a[1:0] == 2'b00 && a >= 8'h40 && a < 8'(8'h40 + 8 * NCORE);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [NCORE-1:0] wf);
      if (a[1:0] != 2'b00) return 32'h0;
      if (is_boot(a)) return m_boot[(a - 8'h40) >> 2];
      case (a)
         8'h00: return m_ctrl;
         8'h10: return 32'(m_stat);
         8'h14: return 32'(m_mask);
         8'h80: return m_coh;
         8'h84: return m_snoop;
         8'h90: return 32'(m_pd);
         8'h94: return 32'(wf);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string req_of(input logic [7:0] a);
      if (a[1:0] != 2'b00) return "R11";
      if (is_boot(a)) return "R2";
      case (a)
         8'h10: return "R3";
         8'h14: return "R4";
         8'h18, 8'h1C: return "R5";
         8'h90: return "R7";
         8'h94: return "R9";
         8'h00, 8'h80, 8'h84: return "R10";
         default: return "R11";
      endcase
   endfunction

   task automatic model_reset();
      m_ctrl = '0; m_coh = '0; m_snoop = '0;
      m_stat = '0; m_mask = '1; m_pd = '0; m_pstat = '0;
      for (int w = 0; w < 2 * NCORE; w++) m_boot[w] = (w % 2 == 0) ? 32'hFFFF_0000 : 32'h0;
   endtask

   task automatic step(input logic s, input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [IRQ_W-1:0] set, input logic [NCORE-1:0] wf);
      logic [IRQ_W-1:0] clr;
      @(negedge clk);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; irq_set_i = set; wfi_i = wf;
      #1;
      if (s && !w) chk(req_of(a), 64'(bus_rdata), 64'(exp_read(a, wf)));
      else         chk("R12", 64'(bus_rdata), 64'h0);
      chk("R6", 64'(irq_o), 64'(|(m_stat & ~m_mask)));
      chk("R8", 64'(wfi_o), 64'(m_pd & wf));
      chk("R7", 64'(pwr_stat_o), 64'(m_pstat));
      for (int c = 0; c < NCORE; c++) chk("R2", boot_addr_o[c], {m_boot[2*c+1], m_boot[2*c]});
      @(posedge clk);
      clr = '0;
      if (s && w && a[1:0] == 2'b00) begin
         if (is_boot(a)) m_boot[(a - 8'h40) >> 2] = d;
         else case (a)
            8'h00: m_ctrl = d;
            8'h10: clr = d[IRQ_W-1:0];
            8'h18: m_mask = m_mask & ~d[IRQ_W-1:0];
            8'h1C: m_mask = m_mask | d[IRQ_W-1:0];
            8'h80: m_coh = d;
            8'h84: m_snoop = d;
            8'h90: begin m_pd = d[NCORE-1:0]; m_pstat = d[NCORE-1:0]; end
            default: ;
         endcase
      end
      m_stat = (m_stat & ~clr) | set;
   endtask

   task automatic rd(input logic [7:0] a, input logic [NCORE-1:0] wf);
      step(1'b1, 1'b0, a, 32'h0, '0, wf);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [IRQ_W-1:0] set);
      step(1'b1, 1'b1, a, d, set, 4'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] offs [16];
      offs = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h40, 8'h44, 8'h48,
               8'h4C, 8'h50, 8'h54, 8'h58, 8'h5C, 8'h80, 8'h84, 8'h90};
      void'($urandom(32'h00C0FFEE));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      // R1: reset state with every idle input high
      chk("R1", 64'(wfi_o), 64'h0);
      chk("R1", 64'(pwr_stat_o), 64'h0);
      chk("R1", 64'(irq_o), 64'h0);
      for (int c = 0; c < NCORE; c++) chk("R1", boot_addr_o[c], 64'h0000_0000_FFFF_0000);
      rst_n = 1'b1;
      rd(8'h14, 4'hF);
      rd(8'h10, 4'hF);
      rd(8'h90, 4'hF);
      // R2: core 1 low and high words
      wr(8'h48, 32'h1234_5678, '0);
      wr(8'h4C, 32'h9ABC_DEF0, '0);
      rd(8'h48, 4'h0);
      rd(8'h4C, 4'h0);
      chk("R2", boot_addr_o[1], 64'h9ABC_DEF0_1234_5678);
      // R3 / R5 / R6
      step(1'b0, 1'b0, 8'h00, 32'h0, 8'h05, 4'h0);
      rd(8'h10, 4'h0);
      wr(8'h18, 32'h0000_0001, '0);
      rd(8'h18, 4'h0);
      wr(8'h10, 32'h0000_0005, 8'h01);
      rd(8'h10, 4'h0);
      wr(8'h1C, 32'hFFFF_FFFF, '0);
      rd(8'h1C, 4'h0);
      // R4: mask write ignored
      wr(8'h14, 32'h0, '0);
      rd(8'h14, 4'h0);
      // R11: unaligned and empty offsets
      wr(8'h92, 32'hFFFF_FFFF, '0);
      wr(8'h41, 32'h0, '0);
      wr(8'h20, 32'hFFFF_FFFF, '0);
      rd(8'h90, 4'h0);
      rd(8'h41, 4'h0);
      rd(8'h60, 4'h0);
      // R7 / R8 / R9
      wr(8'h90, 32'hFFFF_FFF5, '0);
      rd(8'h90, 4'hF);
      rd(8'h94, 4'hA);
      step(1'b0, 1'b0, 8'h00, 32'h0, '0, 4'h3);
      // R10 storage
      wr(8'h80, 32'hA5A5_0001, '0);
      wr(8'h84, 32'h5A5A_0002, '0);
      wr(8'h00, 32'h0F0F_0003, '0);
      rd(8'h80, 4'h0); rd(8'h84, 4'h0); rd(8'h00, 4'h0);
      // random phase
      for (int i = 0; i < 600; i++) begin
         logic [7:0] a;
         logic [IRQ_W-1:0] set;
         a   = ($urandom % 4 == 0) ? 8'($urandom) : offs[$urandom % 16];
         set = ($urandom % 4 == 0) ? IRQ_W'($urandom) : '0;
         step($urandom % 5 != 0, $urandom % 2 == 1, a, $urandom, set, NCORE'($urandom));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule